// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, from the 48-bit destination address at the head of an incoming Ethernet frame, whether the frame should be kept. The address comes in one bit per clock in the order it appears on the wire. A strobe marks the first bit and a qualifier marks each valid bit. While the bits arrive, the block does three things at once. It compares them against a programmed 48-bit station address. It checks whether every bit is one, which marks a broadcast. It also runs a CRC-32 over them.

The first bit received is the group flag. If it is zero the address is individual, and the frame is kept only when all 48 bits match the station address. If it is one the address is a group (multicast) address. Six bits of the finished CRC then pick one bit of a 64-bit hash filter, and that bit gives the answer. A broadcast is kept unless a blocking control bit is set. A promiscuous control bit keeps every frame.

One cycle after the 48th bit is taken, the verdict appears together with a one-cycle done strobe.

Top module: `dest_addr_filter`

## Requirements
- R1: While reset is high and on the cycle after it, `done` and `accept` are 0. `accept` is only ever 1 together with `done`.
- R2: Wire bit i (i = 0 is the first bit) is compared with `station_addr[i]`. Byte k of the address on the wire therefore uses bits 8k+7..8k, starting from bit 8k. An individual address (first bit 0) is accepted only when all 48 bits match. A single mismatching bit, including bit 40 or bit 47, causes a reject.
- R3: For a group address (first bit 1) that is not broadcast, the CRC register is preset to all ones at the first bit. For each received bit b it is then updated as fb = crc[31] ^ b, crc = {crc[30:0],0} ^ (fb ? 32'h04C11DB7 : 0). After 48 bits, the hash index is crc[31:26], with crc[26] as the least significant index bit. The frame is accepted exactly when `hash_filter[index]` is 1.
- R4: When `hash_filter` is all zeros and promiscuous mode is off, every group address except broadcast is rejected.
- R5: An all-ones destination is accepted when `bcast_block` is 0 and rejected when it is 1, whatever the hash filter holds.
- R6: When `promisc` is 1, every frame is accepted, including a broadcast with `bcast_block` set and a mismatching individual address.
- R7: `done` is high for exactly one cycle: the cycle after the clock edge that takes the 48th valid bit. It stays low while the earlier bits are being taken.
- R8: Cycles with `bit_valid` low, in the middle of an address, leave the collected state unchanged. The verdict is the same as for an unbroken address.
- R9: A `bit_start` with `bit_valid` marks a new first bit and discards any partly received address.
- R10: Once 48 bits have been taken, further valid bits without `bit_start` are ignored, and `done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_start | input | 1 | Marks the first address bit (sampled with bit_valid) |
| bit_valid | input | 1 | Qualifies bit_in on this cycle |
| bit_in | input | 1 | Serial destination address bit, wire order |
| station_addr | input | 48 | Programmed station address, bit 0 first on the wire |
| hash_filter | input | 64 | Group address hash filter |
| promisc | input | 1 | Accept every frame |
| bcast_block | input | 1 | Reject broadcast frames |
| accept | output | 1 | Verdict, valid while done is high |
| done | output | 1 | One-cycle strobe marking the verdict |

## Verification
The assertions take for granted that `bit_start` is only raised together with `bit_valid`. They also assume that `promisc` and the other configuration inputs are steady around the cycle that carries the last address bit, because the promiscuous-mode check relates the verdict to the previous cycle's mode input. The bench drives configuration only between frames and always presents the start strobe with a valid bit. Gaps, restarts and extra bits are introduced only through `bit_valid` and `bit_start`.

// File: rtl/daf_pkg.sv
package daf_pkg;
  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = '1;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/daf_bit_track.sv
module daf_bit_track #(
  parameter int ADDR_BITS = 48,
  localparam int CNT_W = $clog2(ADDR_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_start,
  input  logic             bit_valid,
  output logic             take,
  output logic             first,
  output logic             last,
  output logic [CNT_W-1:0] idx
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(ADDR_BITS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BITS - 1);

  logic [CNT_W-1:0] count_q;

  always_comb begin
    idx   = bit_start ? '0 : count_q;
    first = bit_start;
    take  = bit_valid && (bit_start || (count_q != FULL));
    last  = take && (idx == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (bit_start) begin
      count_q <= bit_valid ? CNT_W'(1) : '0;
    end else if (take) begin
      count_q <= count_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/daf_crc.sv
module daf_crc
  import daf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             take,
  input  logic             bit_in,
  output logic [CRC_W-1:0] crc_nxt
);
  logic [CRC_W-1:0] crc_q;

  always_comb begin
    crc_nxt = crc_step(clear ? CRC_SEED : crc_q, bit_in);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= CRC_SEED;
    end else if (take) begin
      crc_q <= crc_nxt;
    end else if (clear) begin
      crc_q <= CRC_SEED;
    end
  end
endmodule

// File: rtl/daf_match.sv
module daf_match #(
  parameter int ADDR_BITS = 48,
  localparam int CNT_W = $clog2(ADDR_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear,
  input  logic                 take,
  input  logic                 bit_in,
  input  logic [CNT_W-1:0]     idx,
  input  logic [ADDR_BITS-1:0] station_addr,
  output logic                 phys_nxt,
  output logic                 ones_nxt,
  output logic                 group_nxt
);
  logic phys_q, ones_q, group_q;
  logic ref_bit;

  always_comb begin
    ref_bit   = (idx < CNT_W'(ADDR_BITS)) ? station_addr[idx] : 1'b0;
    phys_nxt  = (clear ? 1'b1 : phys_q) & (bit_in == ref_bit);
    ones_nxt  = (clear ? 1'b1 : ones_q) & bit_in;
    group_nxt = (idx == '0) ? bit_in : group_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_q  <= 1'b1;
      ones_q  <= 1'b1;
      group_q <= 1'b0;
    end else if (take) begin
      phys_q  <= phys_nxt;
      ones_q  <= ones_nxt;
      group_q <= group_nxt;
    end else if (clear) begin
      phys_q  <= 1'b1;
      ones_q  <= 1'b1;
      group_q <= 1'b0;
    end
  end
endmodule

// File: rtl/daf_decide.sv
module daf_decide #(
  parameter int HASH_BITS = 6,
  parameter int CRC_W = 32,
  localparam int FILTER_W = 1 << HASH_BITS,
  localparam int HASH_LSB = CRC_W - HASH_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                last,
  input  logic                phys_hit,
  input  logic                all_ones,
  input  logic                group,
  input  logic [CRC_W-1:0]    crc,
  input  logic [FILTER_W-1:0] hash_filter,
  input  logic                promisc,
  input  logic                bcast_block,
  output logic                accept,
  output logic                done
);
  logic [HASH_BITS-1:0] hidx;
  logic verdict;

  always_comb begin
    hidx = crc[CRC_W-1:HASH_LSB];
    if (promisc)       verdict = 1'b1;
    else if (all_ones) verdict = !bcast_block;
    else if (group)    verdict = hash_filter[hidx];
    else               verdict = phys_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      accept <= 1'b0;
    end else begin
      done   <= last;
      accept <= last && verdict;
    end
  end
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter #(
  parameter int ADDR_BITS = 48,
  parameter int HASH_BITS = 6,
  localparam int FILTER_W = 1 << HASH_BITS,
  localparam int CNT_W = $clog2(ADDR_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_start,
  input  logic                 bit_valid,
  input  logic                 bit_in,
  input  logic [ADDR_BITS-1:0] station_addr,
  input  logic [FILTER_W-1:0]  hash_filter,
  input  logic                 promisc,
  input  logic                 bcast_block,
  output logic                 accept,
  output logic                 done
);
  import daf_pkg::*;

  logic             take, first, last;
  logic [CNT_W-1:0] idx;
  logic [CRC_W-1:0] crc_nxt;
  logic             phys_nxt, ones_nxt, group_nxt;

  daf_bit_track #(.ADDR_BITS(ADDR_BITS)) u_track (
    .clk(clk), .rst(rst), .bit_start(bit_start), .bit_valid(bit_valid),
    .take(take), .first(first), .last(last), .idx(idx)
  );

  daf_crc u_crc (
    .clk(clk), .rst(rst), .clear(first), .take(take), .bit_in(bit_in),
    .crc_nxt(crc_nxt)
  );

  daf_match #(.ADDR_BITS(ADDR_BITS)) u_match (
    .clk(clk), .rst(rst), .clear(first), .take(take), .bit_in(bit_in),
    .idx(idx), .station_addr(station_addr),
    .phys_nxt(phys_nxt), .ones_nxt(ones_nxt), .group_nxt(group_nxt)
  );

  daf_decide #(.HASH_BITS(HASH_BITS), .CRC_W(CRC_W)) u_decide (
    .clk(clk), .rst(rst), .last(last), .phys_hit(phys_nxt),
    .all_ones(ones_nxt), .group(group_nxt), .crc(crc_nxt),
    .hash_filter(hash_filter), .promisc(promisc), .bcast_block(bcast_block),
    .accept(accept), .done(done)
  );
endmodule

// File: rtl/dest_addr_filter_chk.sv
module dest_addr_filter_chk (
  input logic clk,
  input logic rst,
  input logic bit_valid,
  input logic promisc,
  input logic accept,
  input logic done
);
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (!done && !accept))
    else $error("R1 outputs not quiet after reset");

  p_accept_qual_r1: assert property (@(posedge clk) disable iff (rst) accept |-> done)
    else $error("R1 accept without done");

  p_single_done_r7: assert property (@(posedge clk) disable iff (rst) done |=> !done)
    else $error("R7 done longer than one cycle");

  p_done_after_bit_r8: assert property (@(posedge clk) disable iff (rst) done |-> $past(bit_valid))
    else $error("R8 done without a bit taken on the previous cycle");

  p_promisc_keeps_r6: assert property (@(posedge clk) disable iff (rst) (done && $past(promisc)) |-> accept)
    else $error("R6 promiscuous frame rejected");
endmodule

bind dest_addr_filter dest_addr_filter_chk u_chk (
  .clk(clk), .rst(rst), .bit_valid(bit_valid), .promisc(promisc),
  .accept(accept), .done(done)
);

// File: tb/dest_addr_filter_test.sv
module dest_addr_filter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_start = 1'b0;
  logic        bit_valid = 1'b0;
  logic        bit_in = 1'b0;
  logic [47:0] station_addr = 48'h0;
  logic [63:0] hash_filter = 64'h0;
  logic        promisc = 1'b0;
  logic        bcast_block = 1'b0;
  logic        accept, done;

  int checks = 0;
  int fails = 0;

  localparam logic [47:0] STATION = 48'hA5_3C_12_9E_47_02;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] GROUP_A = 48'h21_43_65_87_A9_01;
  localparam logic [47:0] GROUP_B = 48'h0F_F0_5A_C3_00_33;

  always #5 clk = ~clk;

  dest_addr_filter uut (
    .clk(clk), .rst(rst), .bit_start(bit_start), .bit_valid(bit_valid),
    .bit_in(bit_in), .station_addr(station_addr), .hash_filter(hash_filter),
    .promisc(promisc), .bcast_block(bcast_block), .accept(accept), .done(done)
  );

  function automatic logic [5:0] hash_of(input logic [47:0] a);
    logic [31:0] c;
    logic fb;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      fb = c[31] ^ a[i];
      c = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C11DB7;
    end
    return c[31:26];
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // Drives all 48 bits; gap inserts an idle cycle after every fifth bit.
  // Returns at the negedge after the last bit was taken.
  task automatic send_addr(input logic [47:0] a, input bit gap, input string tag);
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      if (i > 0) check(done, 1'b0, {tag, " R7 early done"});
      bit_start = (i == 0);
      bit_valid = 1'b1;
      bit_in = a[i];
      if (gap && (i % 5 == 4) && i != 47) begin
        @(negedge clk);
        bit_start = 1'b0;
        bit_valid = 1'b0;
        bit_in = ~bit_in;
      end
    end
    @(negedge clk);
    bit_start = 1'b0;
    bit_valid = 1'b0;
  endtask

  task automatic frame(input logic [47:0] a, input bit gap, input logic exp, input string tag);
    send_addr(a, gap, tag);
    check(done, 1'b1, {tag, " R7 done"});
    check(accept, exp, tag);
    @(negedge clk);
    check(done, 1'b0, {tag, " R7 single"});
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(done, 1'b0, "R1 reset done");
    check(accept, 1'b0, "R1 reset accept");
    rst = 1'b0;
    @(negedge clk);
    check(done, 1'b0, "R1 after reset");
  endtask

  task automatic t_unicast();
    station_addr = STATION;
    frame(STATION, 1'b0, 1'b1, "R2 match");
    frame(STATION ^ 48'h01_00_0000_0000, 1'b0, 1'b0, "R2 bit40 miss");
    frame(STATION ^ 48'h80_00_0000_0000, 1'b0, 1'b0, "R2 bit47 miss");
    frame(STATION ^ 48'h00_00_0000_0100, 1'b0, 1'b0, "R2 bit8 miss");
  endtask

  task automatic t_group();
    hash_filter = 64'h0;
    hash_filter[hash_of(GROUP_A)] = 1'b1;
    frame(GROUP_A, 1'b0, 1'b1, "R3 hit A");
    hash_filter = ~hash_filter;
    frame(GROUP_A, 1'b0, 1'b0, "R3 miss A");
    hash_filter = 64'h0;
    hash_filter[hash_of(GROUP_B)] = 1'b1;
    frame(GROUP_B, 1'b0, 1'b1, "R3 hit B");
    hash_filter = 64'h0;
    frame(GROUP_A, 1'b0, 1'b0, "R4 zero A");
    frame(GROUP_B, 1'b0, 1'b0, "R4 zero B");
  endtask

  task automatic t_bcast();
    hash_filter = 64'h0;
    bcast_block = 1'b0;
    frame(BCAST, 1'b0, 1'b1, "R5 bcast open");
    hash_filter = '1;
    bcast_block = 1'b1;
    frame(BCAST, 1'b0, 1'b0, "R5 bcast blocked");
    bcast_block = 1'b0;
  endtask

  task automatic t_promisc();
    promisc = 1'b1;
    bcast_block = 1'b1;
    hash_filter = 64'h0;
    frame(BCAST, 1'b0, 1'b1, "R6 bcast");
    frame(STATION ^ 48'h10, 1'b0, 1'b1, "R6 unicast miss");
    frame(GROUP_A, 1'b0, 1'b1, "R6 group zero filter");
    promisc = 1'b0;
    bcast_block = 1'b0;
  endtask

  task automatic t_gaps();
    hash_filter = 64'h0;
    hash_filter[hash_of(GROUP_B)] = 1'b1;
    frame(GROUP_B, 1'b1, 1'b1, "R8 gapped group");
    frame(STATION, 1'b1, 1'b1, "R8 gapped match");
    frame(STATION ^ 48'h4000, 1'b1, 1'b0, "R8 gapped miss");
  endtask

  task automatic t_restart();
    // partial broadcast, then a fresh unicast match
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      bit_start = (i == 0);
      bit_valid = 1'b1;
      bit_in = 1'b1;
    end
    frame(STATION, 1'b0, 1'b1, "R9 restart");
  endtask

  task automatic t_extra();
    frame(STATION, 1'b0, 1'b1, "R10 base");
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      check(done, 1'b0, "R10 extra bits");
      bit_valid = 1'b1;
      bit_in = STATION[i % 48];
    end
    @(negedge clk);
    check(done, 1'b0, "R10 extra bits");
    bit_valid = 1'b0;
    @(negedge clk);
    check(done, 1'b0, "R10 extra bits");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_unicast();
    t_group();
    t_bcast();
    t_promisc();
    t_gaps();
    t_restart();
    t_extra();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule